// File: doc/BRIEF.md
# Leaky ADPCM Sample Decoder

This block expands a stream of 4-bit adaptive differential codes into signed audio samples. It holds two pieces of state: a signed 16-bit running value and an adaptive step size. Each code chooses how far the running value moves, scaled by the current step, and how the step grows or shrinks for the next code.

Before each new difference is added, the running value is scaled by 254/256. Because of this decay, the output drifts back toward zero when the input carries no energy, and a corrupted code does not leave a permanent offset. Both the running value and the step are clamped, so no input sequence can make either one wrap.

A producer presents one code together with a strobe. The decoded sample appears on the next clock edge with a one-cycle valid flag. Codes may arrive on every cycle, or with any number of idle cycles between them.

Top module: `adpcm_leaky_decoder`

## Requirements
- R1: During synchronous reset (`rst_n` low at a rising edge) the running value becomes 0, the step becomes 127, `sample` becomes 0 and `sample_valid` becomes 0.
- R2: Bit 3 of `code` selects the direction (1 = subtract). Bits 2:0 give the magnitude m, from 0 to 7.
- R3: The difference magnitude is ((2m+1) × step) >> 3, limited to 32767. It is then negated when bit 3 is set.
- R4: Before the difference is added, the previous running value is multiplied by 254 and shifted arithmetically right by 8.
- R5: The sum of the decayed value and the difference is limited to the range −32768 to 32767.
- R6: The next step is (step × F(m)) >> 8, computed from the step held before this code. F is 230 for m = 0 to 3, 307 for m = 4, 409 for m = 5, 512 for m = 6 and 614 for m = 7.
- R7: The next step is clamped to the range 127 to 24576.
- R8: `sample_valid` is high in exactly the cycle after each cycle in which `code_valid` is high. `sample` then carries the 16-bit running value shifted arithmetically right by 4. When no strobe is given, both `sample` and the internal state stay unchanged.
- R9: Reset takes priority over a code strobed in the same cycle. The first code after reset decodes from the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_valid | input | 1 | Strobe: `code` is valid this cycle |
| code | input | 4 | ADPCM code: bit 3 is the sign, bits 2:0 the magnitude |
| sample_valid | output | 1 | One-cycle flag: `sample` carries a new value |
| sample | output | 12 | Decoded signed sample |

## Verification
Several properties are checked on every cycle. The strobe-to-valid latency, holding still on idle cycles, and the step staying inside its bounds are all covered. So are the reset values, `sample` matching the top of the running value, and a difference of a given sign never pushing the value across zero the opposite way. The exact arithmetic can only be shown by the bench's scenarios, where a behavioural model decodes the same stream. That arithmetic covers the decay factor, the multiplier table, delta and sum saturation, and the lower step clamp. Directed scenarios drive the value to both rails, reach the lower step bound, and strobe a code during reset. An LFSR-driven stream with idle gaps then exercises arbitrary code sequences.

// File: rtl/adpcm_dec_pkg.sv
// Package: shared code layout and the step-adaptation factor lookup.
// Assumes 3-bit magnitude; factors are fixed by the decoding scheme.
package adpcm_dec_pkg;

    localparam int FACTOR_W = 10;

    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } adpcm_code_t;

    // Step multiplier (in 1/256 units) indexed by code magnitude.
    function automatic logic [FACTOR_W-1:0] step_factor(input logic [2:0] m);
        case (m)
            3'd4:    step_factor = FACTOR_W'(307);
            3'd5:    step_factor = FACTOR_W'(409);
            3'd6:    step_factor = FACTOR_W'(512);
            3'd7:    step_factor = FACTOR_W'(614);
            default: step_factor = FACTOR_W'(230);
        endcase
    endfunction

endpackage

// File: rtl/adpcm_delta_gen.sv
// Difference generator: scales the odd multiplier (2m+1) by the step,
// divides by 8, limits to the largest positive accumulator value and
// applies the code's sign. Purely combinational.
module adpcm_delta_gen
    import adpcm_dec_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int STEP_W = 15
) (
    input  adpcm_code_t              code_in,
    input  logic [STEP_W-1:0]        step,
    output logic signed [ACC_W-1:0]  delta
);
    localparam int PROD_W = STEP_W + 4;
    localparam logic [PROD_W-1:0] DMAX = PROD_W'((2 ** (ACC_W - 1)) - 1);

    logic [3:0]        odd_mult;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [ACC_W-1:0]  mag_sat;

    // Form (2m+1)*step and divide by eight.
    always_comb begin
        odd_mult = {code_in.mag, 1'b1};
        prod     = PROD_W'(odd_mult) * PROD_W'(step);
        scaled   = prod >> 3;
    end

    // Limit the magnitude and apply the direction bit.
    always_comb begin
        if (scaled > DMAX) mag_sat = ACC_W'(DMAX);
        else               mag_sat = ACC_W'(scaled);
        delta = code_in.neg ? -$signed(mag_sat) : $signed(mag_sat);
    end

endmodule

// File: rtl/adpcm_leak_sum.sv
// Leak-and-add stage: decays the previous accumulator by LEAK_NUM/2^LEAK_SHIFT
// (floor, arithmetic) and adds the signed difference with saturation to the
// accumulator range. Assumes LEAK_NUM < 2^LEAK_SHIFT so the decayed value fits.
module adpcm_leak_sum #(
    parameter int ACC_W      = 16,
    parameter int LEAK_NUM   = 254,
    parameter int LEAK_SHIFT = 8
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [ACC_W-1:0] delta,
    output logic signed [ACC_W-1:0] acc_next
);
    localparam int LN_W  = $clog2(LEAK_NUM + 1);
    localparam int MUL_W = ACC_W + LN_W + 1;
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [MUL_W-1:0] LEAK_K = MUL_W'(LEAK_NUM);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [MUL_W-1:0] acc_ext;
    logic signed [MUL_W-1:0] prod;
    logic signed [ACC_W-1:0] leaked;
    logic signed [SUM_W-1:0] sum;

    // Scale the previous value by the leak factor.
    always_comb begin
        acc_ext = {{(MUL_W-ACC_W){acc[ACC_W-1]}}, acc};
        prod    = acc_ext * LEAK_K;
        leaked  = ACC_W'(prod >>> LEAK_SHIFT);
    end

    // Add with one guard bit and clip to the accumulator range.
    always_comb begin
        sum = {leaked[ACC_W-1], leaked} + {delta[ACC_W-1], delta};
        if (sum[SUM_W-1] != sum[SUM_W-2])
            acc_next = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
        else
            acc_next = ACC_W'(sum);
    end

endmodule

// File: rtl/adpcm_step_adapt.sv
// Step adaptation: multiplies the current step by the table factor for the
// code magnitude, divides by 256 and clamps to [STEP_MIN, STEP_MAX].
// Combinational; uses the step value from before the update.
module adpcm_step_adapt
    import adpcm_dec_pkg::*;
#(
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 127,
    parameter int STEP_MAX = 24576
) (
    input  logic [2:0]        mag,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] step_next
);
    localparam int PROD_W = STEP_W + FACTOR_W;
    localparam logic [PROD_W-1:0] LO = PROD_W'(STEP_MIN);
    localparam logic [PROD_W-1:0] HI = PROD_W'(STEP_MAX);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    // Apply the multiplier and the 1/256 scale.
    always_comb begin
        prod   = PROD_W'(step) * PROD_W'(step_factor(mag));
        scaled = prod >> 8;
    end

    // Hold the step inside its legal bounds.
    always_comb begin
        if (scaled < LO)      step_next = STEP_W'(LO);
        else if (scaled > HI) step_next = STEP_W'(HI);
        else                  step_next = STEP_W'(scaled);
    end

endmodule

// File: rtl/adpcm_leaky_decoder.sv
// Top: leaky 4-bit ADPCM decoder. Holds the running value and step in
// registers, updates both on each strobed code and presents the upper
// OUT_W bits of the new value one cycle later with a valid flag.
// Assumes a single clock; rst_n is synchronous and active low.
module adpcm_leaky_decoder
    import adpcm_dec_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int OUT_W      = 12,
    parameter int STEP_MIN   = 127,
    parameter int STEP_MAX   = 24576,
    parameter int LEAK_NUM   = 254,
    parameter int LEAK_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [3:0]       code,
    output logic             sample_valid,
    output logic [OUT_W-1:0] sample
);
    localparam int STEP_W = $clog2(STEP_MAX + 1);

    adpcm_code_t              code_s;
    logic signed [ACC_W-1:0]  acc_q;
    logic [STEP_W-1:0]        step_q;
    logic signed [ACC_W-1:0]  delta;
    logic signed [ACC_W-1:0]  acc_next;
    logic [STEP_W-1:0]        step_next;

    assign code_s = adpcm_code_t'(code);

    adpcm_delta_gen #(.ACC_W(ACC_W), .STEP_W(STEP_W)) delta_i (
        .code_in (code_s),
        .step    (step_q),
        .delta   (delta)
    );

    adpcm_leak_sum #(.ACC_W(ACC_W), .LEAK_NUM(LEAK_NUM), .LEAK_SHIFT(LEAK_SHIFT)) leak_i (
        .acc      (acc_q),
        .delta    (delta),
        .acc_next (acc_next)
    );

    adpcm_step_adapt #(.STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) adapt_i (
        .mag       (code_s.mag),
        .step      (step_q),
        .step_next (step_next)
    );

    // Decoder state: update value and step on each strobed code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            step_q <= STEP_W'(STEP_MIN);
        end else if (code_valid) begin
            acc_q  <= acc_next;
            step_q <= step_next;
        end
    end

    // Output register: valid one cycle after the strobe, sample held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            sample       <= '0;
        end else begin
            sample_valid <= code_valid;
            if (code_valid) sample <= acc_next[ACC_W-1 -: OUT_W];
        end
    end

endmodule

// File: rtl/adpcm_leaky_decoder_chk.sv
// Checker: cycle-level properties of the decoder, bound to the top module.
module adpcm_leaky_decoder_chk #(
    parameter int ACC_W    = 16,
    parameter int OUT_W    = 12,
    parameter int STEP_W   = 15,
    parameter int STEP_MIN = 127,
    parameter int STEP_MAX = 24576
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    code_valid,
    input logic [3:0]              code,
    input logic                    sample_valid,
    input logic [OUT_W-1:0]        sample,
    input logic signed [ACC_W-1:0] acc_q,
    input logic [STEP_W-1:0]       step_q
);
    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && step_q == STEP_W'(STEP_MIN) && !sample_valid && sample == '0));

    // R8: valid exactly one cycle after a strobe
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> sample_valid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> !sample_valid);

    // R8: idle cycles change nothing
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> ($stable(sample) && $stable(acc_q) && $stable(step_q)));

    // R8: sample is the top of the running value
    a_r8_sample_top: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample == acc_q[ACC_W-1 -: OUT_W]));

    // R7: step stays within bounds
    a_r7_step_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q >= STEP_W'(STEP_MIN) && step_q <= STEP_W'(STEP_MAX)));

    // R2: an upward code never makes a non-negative value negative, and vice versa
    a_r2_up_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !code[3] && !acc_q[ACC_W-1]) |=> !acc_q[ACC_W-1]);
    a_r2_down_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code[3] && (acc_q[ACC_W-1] || acc_q == '0)) |=> (acc_q[ACC_W-1] || acc_q == '0));

endmodule

bind adpcm_leaky_decoder adpcm_leaky_decoder_chk #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .STEP_W(STEP_W),
    .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
    .sample_valid(sample_valid), .sample(sample),
    .acc_q(acc_q), .step_q(step_q)
);

// File: tb/adpcm_leaky_decoder_tb_top.sv
`timescale 1ns/1ps
module adpcm_leaky_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [3:0]  code = 4'd0;
    logic        sample_valid;
    logic [11:0] sample;

    int n_tests = 0;
    int n_fail  = 0;
    int m_acc   = 0;
    int m_step  = 127;
    int exp_smp = 0;
    bit exp_vld = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    adpcm_leaky_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
        .sample_valid(sample_valid), .sample(sample)
    );

    function automatic int factor(input int m);
        case (m)
            4: return 307;
            5: return 409;
            6: return 512;
            7: return 614;
            default: return 230;
        endcase
    endfunction

    function automatic int got_smp();
        return int'($signed(sample));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model: one code applied to integer state.
    task automatic model_code(input logic [3:0] c);
        int m, d, v, ns;
        m = int'(c[2:0]);
        d = ((2 * m + 1) * m_step) >>> 3;
        if (d > 32767) d = 32767;
        if (c[3]) d = -d;
        v = ((m_acc * 254) >>> 8) + d;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        ns = (m_step * factor(m)) >> 8;
        if (ns < 127) ns = 127;
        if (ns > 24576) ns = 24576;
        m_acc   = v;
        m_step  = ns;
        exp_smp = v >>> 4;
    endtask

    // One clock: drive at the falling edge, compare at the next falling edge.
    task automatic cyc(input bit v, input logic [3:0] c);
        code_valid = v;
        code       = c;
        if (v) model_code(c);
        exp_vld = v;
        @(posedge clk);
        @(negedge clk);
        check(sample_valid == exp_vld, "R8 valid", int'(sample_valid), int'(exp_vld));
        check(got_smp() == exp_smp, "R3 R4 R5 R6 model sample", got_smp(), exp_smp);
    endtask

    task automatic do_reset(input bit strobe);
        rst_n      = 1'b0;
        code_valid = strobe;
        code       = 4'd7;
        @(posedge clk);
        @(negedge clk);
        m_acc = 0; m_step = 127; exp_smp = 0; exp_vld = 1'b0;
        check(sample_valid == 1'b0, "R1 reset valid", int'(sample_valid), 0);
        check(got_smp() == 0, "R1 reset sample", got_smp(), 0);
        rst_n      = 1'b1;
        code_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        do_reset(1'b0);

        // R1 R3: first code from reset state
        cyc(1'b1, 4'd7);
        check(got_smp() == 14, "R1 R3 first code", got_smp(), 14);

        // R8: idle cycles hold the sample
        for (int i = 0; i < 5; i++) cyc(1'b0, 4'd3);
        check(got_smp() == 14, "R8 hold", got_smp(), 14);

        // R7: step clamped at its lower bound
        do_reset(1'b0);
        cyc(1'b1, 4'd0);
        cyc(1'b1, 4'd7);
        check(got_smp() == 15, "R7 lower clamp", got_smp(), 15);

        // R6: table factor for m = 4
        do_reset(1'b0);
        cyc(1'b1, 4'd4);
        cyc(1'b1, 4'd7);
        check(got_smp() == 26, "R6 factor", got_smp(), 26);

        // R5: positive rail
        do_reset(1'b0);
        for (int i = 0; i < 40; i++) cyc(1'b1, 4'd7);
        check(got_smp() == 2047, "R5 upper rail", got_smp(), 2047);

        // R4 R2: decay applied before a downward step
        cyc(1'b1, 4'd8);
        check(got_smp() == 1839, "R4 R2 leak then subtract", got_smp(), 1839);

        // R5 R2 R3: negative rail with saturated difference
        for (int i = 0; i < 40; i++) cyc(1'b1, 4'd15);
        check(got_smp() == -2048, "R5 R2 lower rail", got_smp(), -2048);

        // R9: reset wins over a simultaneous strobe
        do_reset(1'b1);
        cyc(1'b1, 4'd7);
        check(got_smp() == 14, "R9 decode after reset", got_smp(), 14);

        // Pseudo-random stream with idle gaps, compared every cycle
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[5:4] != 2'b00, lfsr[3:0]);
        end
        for (int i = 0; i < 200; i++) cyc(1'b1, (i % 3 == 0) ? 4'd15 : 4'd6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule